// File: doc/BRIEF.md
# Configurable-Edge SPI Master

This block is a single-transfer SPI master controlled through three write-only settings registers: a clock divider, a control word and a transmit word. Software first programs the divider and the control word. The control word holds the slave-select mask, the number of bits to move, and the SCLK edges on which MOSI is launched and MISO is captured. A write to the transmit word then starts one transfer. The transmit value is MSB-aligned: bit 31 goes out first, and only as many bits as the count asks for are sent.

While the transfer runs, the block holds the selected slave-select lines low and toggles SCLK from an idle-low level. Bits arriving on MISO are shifted into a receive register. When the transfer ends, that register is copied to the readback output, right-aligned. A busy output marks the whole transfer, from the starting write until the selects are released. The control word and the divider stay in force for every later transfer until software writes them again. Their values are captured at the start of each transfer, so a transfer in progress never sees a change to them.

Top module: `spim_master`

## Requirements
- R1: After synchronous reset, busy is 0, every ss_n line is 1, sclk is 0, rd_data is 0, and the divider holds DIV_RESET (default 4).
- R2: One SCLK half-period lasts div+1 clock cycles. busy stays high for exactly (2N+1)*(div+1) cycles after the clock edge that accepts the starting write. This covers one leading half-period, 2N SCLK edges and one trailing half-period.
- R3: During a transfer, ss_n equals the inverse of control bits [NUM_SS-1:0] (active low) and does not change. When the block is not busy, all ss_n lines are 1.
- R4: Control bits [29:24] give the bit count N. Values 1 to 32 are used as written; 0 and any value above 32 mean 32. A transfer produces exactly N rising SCLK edges.
- R5: MOSI carries the transmit word MSB first, starting at bit 31. If control bit 31 is 1, MOSI changes on falling SCLK edges and the first bit is valid before the first rising edge. If control bit 31 is 0, MOSI changes on rising edges.
- R6: If control bit 30 is 1, MISO is sampled on rising SCLK edges. If control bit 30 is 0, MISO is sampled on falling edges.
- R7: rd_data is updated on the edge where busy falls. The N received bits are right-aligned, with the last sampled bit in bit 0 and zeros above. rd_data then holds until the next transfer ends.
- R8: Register addresses are 0 = divider, 1 = control, 2 = transmit word. A write to address 2 while the block is idle starts a transfer. Control and divider values persist across transfers until they are rewritten.
- R9: A write to address 2 while busy is ignored. The running transfer keeps its timing and data, and no further transfer follows.
- R10: SCLK is low whenever the block is idle, and it is low when busy falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select (0 divider, 1 control, 2 transmit) |
| wr_data | input | 32 | Register write value |
| miso | input | 1 | Serial data from the slave |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data to the slave |
| ss_n | output | NUM_SS | Active-low slave selects |
| busy | output | 1 | High while a transfer is in progress |
| rd_data | output | 32 | Right-aligned received bits of the last transfer |

## Verification
The bench builds the block with NUM_SS = 8, DIV_W = 8 and DIV_RESET = 4. This keeps the select mask small enough to check every line, and the first transfer runs at the reset divider. Further transfers reprogram the divider to 0, 1 and 2, which brings the fastest case within reach: one cycle per half-period, where MISO must be driven and then sampled one cycle apart. A bench-side slave model covers all four pairings of launch and capture edge. It also covers bit counts of 1, 4, 8, 13 and 32, including the count field at 0 and at values above 32. Busy length is measured in cycles to pin down each divider setting.

// File: rtl/spim_pkg.sv
// Package: shared constants, the control-word layout and the FSM state type
// for the SPI master. Assumes a 32-bit register data path.
package spim_pkg;

    localparam int WORD_W  = 32;
    localparam int NBITS_W = 6;
    localparam int EDGE_W  = NBITS_W + 1;

    localparam logic [1:0] ADDR_DIV  = 2'd0;
    localparam logic [1:0] ADDR_CTRL = 2'd1;
    localparam logic [1:0] ADDR_DATA = 2'd2;

    // Control word; the field order follows the bit positions software uses.
    typedef struct packed {
        logic               launch_on_fall;  // bit 31
        logic               sample_on_rise;  // bit 30
        logic [NBITS_W-1:0] bit_count;       // bits 29:24
        logic [23:0]        sel_mask;        // bits 23:0
    } ctrl_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LEAD  = 2'd1,
        ST_RUN   = 2'd2,
        ST_TRAIL = 2'd3
    } xfer_state_t;

    // Maps the raw count field to an effective count of 1..32.
    function automatic logic [NBITS_W-1:0] eff_bits(input logic [NBITS_W-1:0] f);
        if (f == '0 || f > NBITS_W'(WORD_W))
            return NBITS_W'(WORD_W);
        return f;
    endfunction

endpackage

// File: rtl/spim_regs.sv
// Module: settings registers for the SPI master. Holds the divider and the
// control word, and raises a one-cycle start pulse for a write to the
// transmit address while the block is idle. Assumes DIV_W <= 32.
module spim_regs
    import spim_pkg::*;
#(
    parameter int DIV_W     = 16,
    parameter int DIV_RESET = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [1:0]          wr_addr,
    input  logic [WORD_W-1:0]   wr_data,
    input  logic                busy,
    output logic [DIV_W-1:0]    div_q,
    output ctrl_t               ctrl_q,
    output logic                start
);

    // Stores divider and control writes; either may change at any time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q  <= DIV_RESET[DIV_W-1:0];
            ctrl_q <= '0;
        end else if (wr_en) begin
            if (wr_addr == ADDR_DIV)
                div_q <= wr_data[DIV_W-1:0];
            if (wr_addr == ADDR_CTRL)
                ctrl_q <= ctrl_t'(wr_data);
        end
    end

    // Start request: a transmit write is taken only while idle.
    always_comb begin
        start = wr_en && (wr_addr == ADDR_DATA) && !busy;
    end

endmodule

// File: rtl/spim_tick.sv
// Module: half-period timer. While run is high it pulses tick once every
// div+1 cycles. Assumes div stays stable while run is high.
module spim_tick #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [DIV_W-1:0] cnt;

    // Counts cycles inside one half-period and restarts on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)
            cnt <= '0;
        else if (cnt >= div)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    // Tick marks the last cycle of a half-period.
    always_comb begin
        tick = run && (cnt >= div);
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> cnt <= div);  // R2

endmodule

// File: rtl/spim_shift.sv
// Module: transmit and receive shift registers. The edge modes are latched
// at load. MOSI is launched and MISO captured on the SCLK edges those modes
// select. Assumes edge_rise and edge_fall are single-cycle strobes.
module spim_shift
    import spim_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] load_data,
    input  logic              cfg_launch_fall,
    input  logic              cfg_sample_rise,
    input  logic              edge_rise,
    input  logic              edge_fall,
    input  logic              miso,
    output logic              mosi,
    output logic [WORD_W-1:0] rx_word
);

    logic [WORD_W-1:0] tx_q;
    logic              launch_fall_q;
    logic              sample_rise_q;
    logic              launch_now;
    logic              sample_now;

    // Selects the SCLK edges that shift out and capture in the active mode.
    always_comb begin
        launch_now = launch_fall_q ? edge_fall : edge_rise;
        sample_now = sample_rise_q ? edge_rise : edge_fall;
    end

    // Loads the word at start, then shifts MSB first on launch edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q          <= '0;
            mosi          <= 1'b0;
            launch_fall_q <= 1'b0;
            sample_rise_q <= 1'b0;
        end else if (load) begin
            launch_fall_q <= cfg_launch_fall;
            sample_rise_q <= cfg_sample_rise;
            if (cfg_launch_fall) begin
                mosi <= load_data[WORD_W-1];
                tx_q <= load_data << 1;
            end else begin
                mosi <= 1'b0;
                tx_q <= load_data;
            end
        end else if (launch_now) begin
            mosi <= tx_q[WORD_W-1];
            tx_q <= tx_q << 1;
        end
    end

    // Collects received bits right-aligned, newest bit in bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n || load)
            rx_word <= '0;
        else if (sample_now)
            rx_word <= {rx_word[WORD_W-2:0], miso};
    end

    AST_ONE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        !(edge_rise && edge_fall));  // R5

endmodule

// File: rtl/spim_master.sv
// Module: top of the SPI master. Sequences one transfer: a leading
// half-period with selects low, 2N SCLK edges, and a trailing half-period
// before the selects are released. Divider, count and mask are captured at
// start. Assumes NUM_SS <= 24 and DIV_W <= 32.
module spim_master
    import spim_pkg::*;
#(
    parameter int NUM_SS    = 24,
    parameter int DIV_W     = 16,
    parameter int DIV_RESET = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [31:0]       wr_data,
    input  logic              miso,
    output logic              sclk,
    output logic              mosi,
    output logic [NUM_SS-1:0] ss_n,
    output logic              busy,
    output logic [31:0]       rd_data
);

    xfer_state_t        state;
    logic [DIV_W-1:0]   div_q;
    logic [DIV_W-1:0]   act_div;
    ctrl_t              ctrl_q;
    logic [NBITS_W-1:0] act_bits;
    logic [EDGE_W-1:0]  edge_cnt;
    logic [EDGE_W-1:0]  last_edge;
    logic               start;
    logic               tick;
    logic               edge_rise;
    logic               edge_fall;
    logic [WORD_W-1:0]  rx_word;

    spim_regs #(
        .DIV_W     (DIV_W),
        .DIV_RESET (DIV_RESET)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .busy    (busy),
        .div_q   (div_q),
        .ctrl_q  (ctrl_q),
        .start   (start)
    );

    spim_tick #(
        .DIV_W (DIV_W)
    ) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy),
        .div   (act_div),
        .tick  (tick)
    );

    spim_shift u_shift (
        .clk             (clk),
        .rst_n           (rst_n),
        .load            (start),
        .load_data       (wr_data),
        .cfg_launch_fall (ctrl_q.launch_on_fall),
        .cfg_sample_rise (ctrl_q.sample_on_rise),
        .edge_rise       (edge_rise),
        .edge_fall       (edge_fall),
        .miso            (miso),
        .mosi            (mosi),
        .rx_word         (rx_word)
    );

    // Decodes busy, the edge strobes and the index of the final SCLK edge.
    always_comb begin
        busy      = (state != ST_IDLE);
        edge_rise = tick && ((state == ST_LEAD) || (state == ST_RUN && !sclk));
        edge_fall = tick && (state == ST_RUN) && sclk;
        last_edge = {act_bits, 1'b0} - EDGE_W'(1);
    end

    // Transfer sequencer: drives SCLK, selects, edge count and readback.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            sclk     <= 1'b0;
            ss_n     <= '1;
            edge_cnt <= '0;
            act_div  <= '0;
            act_bits <= '0;
            rd_data  <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        act_div  <= div_q;
                        act_bits <= eff_bits(ctrl_q.bit_count);
                        ss_n     <= ~ctrl_q.sel_mask[NUM_SS-1:0];
                        edge_cnt <= '0;
                        state    <= ST_LEAD;
                    end
                end
                ST_LEAD: begin
                    if (tick) begin
                        sclk     <= 1'b1;
                        edge_cnt <= EDGE_W'(1);
                        state    <= ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (tick) begin
                        sclk     <= ~sclk;
                        edge_cnt <= edge_cnt + 1'b1;
                        if (edge_cnt == last_edge)
                            state <= ST_TRAIL;
                    end
                end
                ST_TRAIL: begin
                    if (tick) begin
                        ss_n    <= '1;
                        rd_data <= rx_word;
                        state   <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_IDLE_SS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> &ss_n);  // R3

    AST_IDLE_SCLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sclk);  // R10

    AST_SCLK_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sclk) |-> $past(tick));  // R2

    AST_EDGE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> edge_cnt <= {act_bits, 1'b0});  // R4

    AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_en && wr_addr == ADDR_DATA) |=> (!busy || ss_n == $past(ss_n)));  // R9

endmodule

// File: tb/spim_master_tb.sv
module spim_master_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NSS        = 8;
    localparam int WATCHDOG   = 150000;

    typedef struct {
        int          nbits;
        int          div;
        logic [31:0] mosi_exp;
        logic [31:0] rd_exp;
        logic [7:0]  ss_exp;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        miso = 1'b0;
    logic        sclk;
    logic        mosi;
    logic [NSS-1:0] ss_n;
    logic        busy;
    logic [31:0] rd_data;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    exp_t sb_q[$];

    // Current programmed configuration, tracked by the driver.
    bit          cur_launch_fall = 0;
    bit          cur_sample_rise = 0;
    int          cur_n = 32;
    int          cur_div = 4;
    logic [7:0]  cur_mask = '0;
    logic [31:0] rx_pat = '0;

    spim_master #(
        .NUM_SS    (NSS),
        .DIV_W     (8),
        .DIV_RESET (4)
    ) u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .miso    (miso),
        .sclk    (sclk),
        .mosi    (mosi),
        .ss_n    (ss_n),
        .busy    (busy),
        .rd_data (rd_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s act=0x%0h exp=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_ctrl(input bit lf, input bit sr, input int cnt_field, input logic [7:0] mask);
        int n;
        n = (cnt_field == 0 || cnt_field > 32) ? 32 : cnt_field;
        cur_launch_fall = lf; cur_sample_rise = sr; cur_n = n; cur_mask = mask;
        wr(2'd1, {lf, sr, 6'(cnt_field), 16'h0, mask});
    endtask

    task automatic set_div(input int d);
        cur_div = d;
        wr(2'd0, 32'(d));
    endtask

    // Driver: push the expected outcome, then start the transfer.
    task automatic push_start(input logic [31:0] data, input logic [31:0] pat);
        exp_t e;
        longint m;
        m = (64'd1 << cur_n) - 1;
        rx_pat     = pat;
        e.nbits    = cur_n;
        e.div      = cur_div;
        e.mosi_exp = 32'(data >> (32 - cur_n));
        e.rd_exp   = 32'(pat & m);
        e.ss_exp   = ~cur_mask;
        sb_q.push_back(e);
        wr(2'd2, data);
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic xfer(input logic [31:0] data, input logic [31:0] pat);
        push_start(data, pat);
        wait_idle();
    endtask

    function automatic logic pat_bit(input int idx);
        if (idx < cur_n) return rx_pat[cur_n-1-idx];
        return 1'b0;
    endfunction

    // Slave model and monitor, sampling away from the active edge.
    bit          prev_busy = 0;
    bit          prev_sclk = 0;
    int          busy_cyc;
    int          rises;
    int          miso_idx;
    logic [31:0] mosi_got;
    logic [7:0]  ss_first;
    bit          ss_moved;
    bit          idle_bad = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (busy && !prev_busy) begin
                busy_cyc = 0; rises = 0; miso_idx = 0; mosi_got = '0;
                ss_first = ss_n; ss_moved = 0;
                if (cur_sample_rise) begin
                    miso = pat_bit(0); miso_idx = 1;
                end else begin
                    miso = 1'b0;
                end
            end
            if (busy) begin
                busy_cyc++;
                if (ss_n != ss_first) ss_moved = 1;
            end else if (prev_busy == 0) begin
                if (sclk !== 1'b0 || ss_n !== '1) idle_bad = 1;
            end
            if (sclk && !prev_sclk) begin
                rises++;
                if (cur_launch_fall) mosi_got = {mosi_got[30:0], mosi};
                if (!cur_sample_rise) begin miso = pat_bit(miso_idx); miso_idx++; end
            end
            if (!sclk && prev_sclk) begin
                if (!cur_launch_fall) mosi_got = {mosi_got[30:0], mosi};
                if (cur_sample_rise) begin miso = pat_bit(miso_idx); miso_idx++; end
            end
            if (!busy && prev_busy) begin
                if (sb_q.size() == 0) begin
                    check(0, "R9", "unexpected transfer", 1, 0);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    check(busy_cyc == (2*e.nbits+1)*(e.div+1), "R2", "busy cycles",
                          busy_cyc, (2*e.nbits+1)*(e.div+1));
                    check(rises == e.nbits, "R4", "rising edges", rises, e.nbits);
                    check(ss_first == e.ss_exp && !ss_moved, "R3", "select lines",
                          ss_first, e.ss_exp);
                    check(mosi_got == e.mosi_exp, "R5", "mosi bits", mosi_got, e.mosi_exp);
                    check(rd_data == e.rd_exp, "R6_R7", "readback", rd_data, e.rd_exp);
                    check(sclk == 1'b0 && ss_n == '1, "R10", "sclk/ss at end",
                          {sclk, ss_n}, {1'b0, 8'hFF});
                end
            end
            prev_busy = busy;
            prev_sclk = sclk;
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired act=running exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state of outputs
        check(busy == 0 && ss_n == '1 && sclk == 0 && rd_data == 0, "R1", "reset outputs",
              {busy, ss_n, sclk, rd_data}, {1'b0, 8'hFF, 1'b0, 32'h0});
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 R8: reset divider 4, launch on fall, sample on rise, 8 bits
        set_ctrl(1, 1, 8, 8'h05);
        xfer(32'hA500_0000, 32'h0000_003C);
        // R8: control persists without a rewrite
        xfer(32'h5A12_3456, 32'h0000_00C3);
        // R5 R6: launch on rise, sample on fall, 13 bits, divider 0
        set_div(0);
        set_ctrl(0, 0, 13, 8'h80);
        xfer(32'hDEAD_BEEF, 32'h0000_1ABC);
        // R4: count field 0 means 32; launch fall, sample fall, divider 2
        set_div(2);
        set_ctrl(1, 0, 0, 8'h3C);
        xfer(32'h1234_5678, 32'h8765_4321);
        // R4 R6: single bit, launch rise, sample rise
        set_ctrl(0, 1, 1, 8'hFF);
        xfer(32'h8000_0000, 32'h0000_0001);
        // R4: count field above 32 clamps to 32, divider 1
        set_div(1);
        set_ctrl(0, 1, 40, 8'h01);
        xfer(32'hF0F0_1E1E, 32'hC001_D00D);
        // R9: transmit write during busy is ignored
        set_ctrl(1, 1, 4, 8'h42);
        push_start(32'h9000_0000, 32'h0000_000A);
        repeat (5) @(negedge clk);
        check(busy == 1, "R9", "busy before second write", busy, 1);
        wr(2'd2, 32'h6000_0000);
        wait_idle();
        repeat (20) @(negedge clk);
        check(busy == 0 && rd_data == 32'h0000_000A, "R9", "no restart, readback held",
              {busy, rd_data}, {1'b0, 32'h0000_000A});
        check(sb_q.size() == 0, "R8", "all transfers seen", sb_q.size(), 0);
        check(!idle_bad, "R10", "idle sclk low and selects high", idle_bad, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule